// File: doc/BRIEF.md
# Relocatable Chip-Select Decoder

This block turns a 16-bit bus address into a one-hot set of chip selects. There is one select each for the on-chip RAM, the on-chip I/O register block, the EEPROM and the ROM. A fifth select goes to the external bus and fires for any address that no internal region claims. The EEPROM and the ROM sit at fixed addresses. The RAM and the register block can each be moved to the start of any 4 KB page.

The placement is held in an 8-bit page register. Its high nibble gives the RAM page and its low nibble gives the register-block page. The page register is itself a location inside the register block, so it moves whenever the block moves. Software can rewrite it only during a short window after reset. Once that window closes, the map is frozen until the next reset.

The decode is purely combinational from the address and the current page register. Only the page register and the window counter are clocked.

Top module: `remap_cs_decoder`

## Requirements
- R1: `sel_o` is always exactly one-hot, with bit 0 = register block, bit 1 = RAM, bit 2 = EEPROM, bit 3 = ROM, bit 4 = external bus.
- R2: After reset the page register holds 0x01. The RAM is therefore at 0x0000–0x00FF and the register block is at 0x1000–0x103F.
- R3: The RAM spans 256 bytes starting at page_reg[7:4] × 0x1000.
- R4: The register block spans 64 bytes starting at page_reg[3:0] × 0x1000.
- R5: The EEPROM always decodes at 0xB600–0xB7FF and the ROM always decodes at 0xE000–0xFFFF.
- R6: Where regions overlap, the register block wins over the RAM, and the RAM wins over the EEPROM and the ROM.
- R7: Any address claimed by no internal region selects the external bus.
- R8: A write with `wr_en_i` high, at offset 0x30 of the register block's current location, loads `wdata_i` into the page register at that clock edge. A write to any other address, or a cycle with `wr_en_i` low, leaves the page register unchanged.
- R9: Writes are accepted only on the first 64 rising clock edges after reset release. Writes on any later edge are ignored until the next reset.
- R10: Several writes may land inside the window. Each write must target the register block at the location set by the previous write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 8 | Write data |
| sel_o | output | 5 | One-hot chip selects {ext, rom, eeprom, ram, regs} |

## Verification
The default map is probed on the first and last byte of every region and on the byte just past each region. These probes separate off-by-one size masks from correct ones. A relocation to 0x23 tests that each nibble drives the correct region, and that the old locations fall through to the external bus.

A page value of 0x00 stacks both regions on page 0. A later value of 0xE0 drops the RAM onto the ROM. Together these expose any error in the priority order.

The write window is tested with a write on the 64th edge and another on the 65th edge, so an off-by-one limit shows up. Writes with a wrong offset and writes without the strobe are probed through the map they would have changed.

// File: rtl/remap_cs_pkg.sv
package remap_cs_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 4;
  localparam int N_SEL  = 5;

  typedef enum logic [2:0] {
    SEL_REGS   = 3'd0,
    SEL_RAM    = 3'd1,
    SEL_EEPROM = 3'd2,
    SEL_ROM    = 3'd3,
    SEL_EXT    = 3'd4
  } sel_idx_e;

  localparam int N_REGION = 4;
endpackage

// File: rtl/remap_cs_window.sv
module remap_cs_window #(
  parameter int WIN_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic open_o
);
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q != CNT_MAX);
endmodule

// File: rtl/remap_cs_region.sv
module remap_cs_region #(
  parameter int ADDR_W    = 16,
  parameter int SIZE_LOG2 = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);
  assign hit_o = (addr_i[ADDR_W-1:SIZE_LOG2] == base_i[ADDR_W-1:SIZE_LOG2]);
endmodule

// File: rtl/remap_cs_prio.sv
module remap_cs_prio #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0] hit_i,
  output logic [N_IN:0]   sel_o
);
  // lowest index wins; top bit is the fall-through
  always_comb begin
    sel_o = '0;
    sel_o[N_IN] = 1'b1;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        sel_o = '0;
        sel_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/remap_cs_decoder.sv
module remap_cs_decoder
  import remap_cs_pkg::*;
#(
  parameter int                WIN_CYCLES  = 64,
  parameter int                PAGE_LOG2   = 12,
  parameter int                RAM_LOG2    = 8,
  parameter int                REGS_LOG2   = 6,
  parameter int                EE_LOG2     = 9,
  parameter int                ROM_LOG2    = 13,
  parameter logic [ADDR_W-1:0] EE_BASE     = 16'hB600,
  parameter logic [ADDR_W-1:0] ROM_BASE    = 16'hE000,
  parameter logic [REGS_LOG2-1:0] INIT_OFS = 6'h30,
  parameter logic [DATA_W-1:0] INIT_RESET  = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SEL-1:0]  sel_o
);
  localparam int LOW_W = PAGE_LOG2;

  logic [DATA_W-1:0] init_q;
  logic              win_open;
  logic [ADDR_W-1:0] base [N_REGION];
  logic [N_REGION-1:0] hit;
  logic              init_we;

  remap_cs_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_o (win_open)
  );

  assign base[SEL_REGS]   = {init_q[PAGE_W-1:0], {LOW_W{1'b0}}};
  assign base[SEL_RAM]    = {init_q[DATA_W-1:PAGE_W], {LOW_W{1'b0}}};
  assign base[SEL_EEPROM] = EE_BASE;
  assign base[SEL_ROM]    = ROM_BASE;

  localparam int SIZES [N_REGION] = '{REGS_LOG2, RAM_LOG2, EE_LOG2, ROM_LOG2};

  for (genvar g = 0; g < N_REGION; g++) begin : g_region
    remap_cs_region #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZES[g])) u_region (
      .addr_i (addr_i),
      .base_i (base[g]),
      .hit_o  (hit[g])
    );
  end

  remap_cs_prio #(.N_IN(N_REGION)) u_prio (
    .hit_i (hit),
    .sel_o (sel_o)
  );

  assign init_we = wr_en_i && win_open && hit[SEL_REGS]
                   && (addr_i[REGS_LOG2-1:0] == INIT_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      init_q <= INIT_RESET;
    else if (init_we) init_q <= wdata_i;
  end
endmodule

// File: rtl/remap_cs_decoder_chk.sv
module remap_cs_decoder_chk #(
  parameter int WIN_CYCLES = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [4:0]  sel_o,
  input logic [7:0]  init_q
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    n_q <= '0;
    else if (n_q != CW'(WIN_CYCLES)) n_q <= n_q + 1'b1;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1); // R1

  AST_INIT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q == '0) |-> (init_q == 8'h01)); // R2

  AST_LATE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q == CW'(WIN_CYCLES)) |=> $stable(init_q)); // R9

  AST_REGS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((addr_i[15:12] == init_q[3:0]) && (addr_i[11:6] == '0)) |-> sel_o[0]); // R6

  AST_EXT_UNCLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[4] |-> ((addr_i < 16'hB600 || addr_i > 16'hB7FF) && addr_i < 16'hE000)); // R7
endmodule

bind remap_cs_decoder remap_cs_decoder_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .sel_o  (sel_o),
  .init_q (init_q)
);

// File: tb/remap_cs_decoder_bench.sv
module remap_cs_decoder_bench;
  localparam logic [4:0] S_REG = 5'b00001, S_RAM = 5'b00010, S_EE = 5'b00100,
                         S_ROM = 5'b01000, S_EXT = 5'b10000;
  logic clk = 0, rst_ni = 0, wr_en = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [4:0] sel;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  remap_cs_decoder u_remap_cs_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .sel_o(sel)
  );

  task automatic chk(input string req, input logic [15:0] a, input logic [4:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (sel !== exp) begin
      errors++;
      $display("FAIL %s addr=%h sel=%b expected=%b", req, a, sel, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; wr_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    addr = a; wdata = d; wr_en = en;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic t_default();
    do_reset();
    chk("R2", 16'h0000, S_RAM);  chk("R3", 16'h00FF, S_RAM);
    chk("R7", 16'h0100, S_EXT);  chk("R4", 16'h1000, S_REG);
    chk("R4", 16'h103F, S_REG);  chk("R7", 16'h1040, S_EXT);
    chk("R5", 16'hB600, S_EE);   chk("R5", 16'hB7FF, S_EE);
    chk("R7", 16'hB800, S_EXT);  chk("R7", 16'hB5FF, S_EXT);
    chk("R5", 16'hE000, S_ROM);  chk("R5", 16'hFFFF, S_ROM);
    chk("R7", 16'hDFFF, S_EXT);  chk("R1", 16'h8000, S_EXT);
  endtask

  task automatic t_remap();
    do_reset();
    wr(16'h1030, 8'h23, 1);
    chk("R3", 16'h2000, S_RAM);  chk("R3", 16'h20FF, S_RAM);
    chk("R3", 16'h2100, S_EXT);  chk("R4", 16'h3000, S_REG);
    chk("R4", 16'h303F, S_REG);  chk("R8", 16'h0000, S_EXT);
    chk("R8", 16'h1030, S_EXT);
  endtask

  task automatic t_overlap();
    do_reset();
    wr(16'h1030, 8'h00, 1);
    chk("R6", 16'h0000, S_REG);  chk("R6", 16'h003F, S_REG);
    chk("R6", 16'h0040, S_RAM);  chk("R6", 16'h00FF, S_RAM);
    wr(16'h0030, 8'hE0, 1); // R10: second write at the moved block
    chk("R10", 16'hE000, S_RAM); chk("R6", 16'hE0FF, S_RAM);
    chk("R6", 16'hE100, S_ROM);  chk("R10", 16'h0030, S_REG);
  endtask

  task automatic t_ignored();
    do_reset();
    wr(16'h1031, 8'h45, 1);
    chk("R8", 16'h4000, S_EXT);  chk("R8", 16'h0000, S_RAM);
    wr(16'h1030, 8'h45, 0);
    chk("R8", 16'h4000, S_EXT);  chk("R8", 16'h1000, S_REG);
    wr(16'h0030, 8'h45, 1); // stale location after no move
    chk("R10", 16'h4000, S_EXT);
  endtask

  task automatic t_window();
    do_reset();
    idle(63);
    wr(16'h1030, 8'h45, 1);
    chk("R9", 16'h4000, S_RAM);  chk("R9", 16'h5000, S_REG);
    do_reset();
    idle(64);
    wr(16'h1030, 8'h45, 1);
    chk("R9", 16'h4000, S_EXT);  chk("R9", 16'h0000, S_RAM);
    chk("R9", 16'h1030, S_REG);
  endtask

  initial begin
    fork
      begin
        t_default();
        t_remap();
        t_overlap();
        t_ignored();
        t_window();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule